// File: doc/BRIEF.md
# PHY Control-Register Bus Master

This block reads and writes 16-bit registers inside a serial PHY's private control space. It has no direct bus to that space. It drives a 20-bit control word and samples a 17-bit status word. Every step of a transfer is a four-phase handshake: the block raises one strobe bit, waits for the PHY's acknowledge to go high, drops the strobe, then waits for acknowledge to go low.

A user asks for one transfer at a time. It presents the operation (read or write), a 16-bit register address and, for writes, 16-bit data. The request is taken in a cycle where `reqReady` is high.

Every transfer starts by capturing the address. A read then pulses the read strobe and latches the returned data. A write captures the data, pulses the write strobe and finally clears the control word. When a transfer ends, `rspDone` pulses for one cycle and `rspErr` is valid in that same cycle. An error means one of the acknowledge waits ran out of polls.

Top module: `phyCrMaster`

## Requirements
- R1: Control word bits are: [15:0] address or data, [16] capture-address, [17] capture-data, [18] write strobe, [19] read strobe. Status word bits are: [15:0] read data, [16] acknowledge.
- R2: A transfer begins with an address phase:
  - one cycle with the address on [15:0] and no strobe;
  - the address plus capture-address until acknowledge is high;
  - the address alone until acknowledge is low.
- R3: A read continues with the read strobe alone (field zero) until acknowledge is high. The status data of that cycle is latched and shown on `rspRdata`. The block then drives an all-zero word until acknowledge is low, and the transfer completes.
- R4: A write continues with:
  - one cycle with the data and no strobe;
  - data plus capture-data until acknowledge is high, then data alone until it is low;
  - the write strobe alone until acknowledge is high, then data alone until it is low;
  - the control word returns to zero in the completion cycle.
- R5: At most one of bits [19:16] of the control word is high in any cycle.
- R6: Acknowledge is polled once per clock while a wait lasts. A wait that matches on its 100th poll (MAX_POLLS) proceeds. A wait that has not matched after 100 polls aborts the transfer.
- R7: On abort, the control word becomes all zero in the cycle where `rspDone` and `rspErr` are both high.
- R8: `reqReady` is high only when the block is idle. A request presented while busy is ignored, and the address and data of the transfer in flight do not change.
- R9: `rspDone` is high for exactly one cycle per transfer. `rspErr` is high in that cycle only on abort.
- R10: After reset the control word is zero, `reqReady` is high and `rspDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | PHY register address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Idle; a request is taken this cycle |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Abort flag, valid with rspDone |
| rspRdata | output | 16 | Last read data |
| crCtrl | output | 20 | Control word to the PHY |
| crStat | input | 17 | Status word from the PHY |

## Verification
The bench attacks the poll bound at both edges:
- an acknowledge that arrives on the 100th poll must pass;
- one that arrives a cycle later must abort.

An off-by-one counter would flip one of these two outcomes.

An acknowledge stuck low stalls the capture steps, and one stuck high stalls the release steps. A design that forgot to clear the control word on abort would leave a strobe asserted at the error pulse.

A request held high while busy, with changed address, checks that the in-flight address is not overwritten. A design that dropped the setup cycle or the final clear would diverge from the cycle-by-cycle model in the control word.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  localparam int DATA_W   = 16;
  localparam int CTRL_W   = DATA_W + 4;
  localparam int STAT_W   = DATA_W + 1;
  localparam int CAPA_BIT = DATA_W;
  localparam int CAPD_BIT = DATA_W + 1;
  localparam int WR_BIT   = DATA_W + 2;
  localparam int RD_BIT   = DATA_W + 3;
  localparam int ACK_BIT  = DATA_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ASET, ST_ACAP, ST_AREL, ST_RSTB, ST_RCLR,
    ST_DSET, ST_DCAP, ST_DREL, ST_WSTB, ST_WREL
  } crState_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ADDR, SEL_ADDR_CAPA, SEL_RD, SEL_DATA, SEL_DATA_CAPD, SEL_WR
  } ctrlSel_e;

  typedef struct packed {
    logic     load;
    ctrlSel_e sel;
    logic     latchRd;
  } dpStrobes_t;
endpackage

// File: rtl/phy_cr_ctrl.sv
module phy_cr_ctrl
  import phy_cr_pkg::*;
#(
  parameter int MAX_POLLS = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       ackIn,
  output logic       reqReady,
  output logic       rspDone,
  output logic       rspErr,
  output dpStrobes_t strb
);
  localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

  crState_e state, nextState;
  logic [CNT_W-1:0] pollCnt;
  logic opWrite;
  logic waitHi, waitLo, isWait, matched, abort, finish;

  function automatic ctrlSel_e selFor(crState_e s);
    case (s)
      ST_ASET, ST_AREL:          return SEL_ADDR;
      ST_ACAP:                   return SEL_ADDR_CAPA;
      ST_RSTB:                   return SEL_RD;
      ST_DSET, ST_DREL, ST_WREL: return SEL_DATA;
      ST_DCAP:                   return SEL_DATA_CAPD;
      ST_WSTB:                   return SEL_WR;
      default:                   return SEL_ZERO;
    endcase
  endfunction

  always_comb begin
    waitHi  = (state == ST_ACAP) || (state == ST_DCAP) ||
              (state == ST_WSTB) || (state == ST_RSTB);
    waitLo  = (state == ST_AREL) || (state == ST_DREL) ||
              (state == ST_WREL) || (state == ST_RCLR);
    isWait  = waitHi || waitLo;
    matched = waitHi ? ackIn : ~ackIn;
  end

  always_comb begin
    nextState    = state;
    strb.load    = 1'b0;
    strb.latchRd = 1'b0;
    abort        = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        nextState = ST_ASET;
        strb.load = 1'b1;
      end
      ST_ASET: nextState = ST_ACAP;
      ST_ACAP: if (matched) nextState = ST_AREL;
      ST_AREL: if (matched) nextState = opWrite ? ST_DSET : ST_RSTB;
      ST_RSTB: if (matched) begin
        nextState    = ST_RCLR;
        strb.latchRd = 1'b1;
      end
      ST_RCLR: if (matched) nextState = ST_IDLE;
      ST_DSET: nextState = ST_DCAP;
      ST_DCAP: if (matched) nextState = ST_DREL;
      ST_DREL: if (matched) nextState = ST_WSTB;
      ST_WSTB: if (matched) nextState = ST_WREL;
      ST_WREL: if (matched) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    if (isWait && !matched && pollCnt == LAST_POLL) begin
      nextState    = ST_IDLE;
      abort        = 1'b1;
      strb.latchRd = 1'b0;
    end
    finish   = (state != ST_IDLE) && (nextState == ST_IDLE) && !abort;
    strb.sel = selFor(nextState);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pollCnt <= '0;
      opWrite <= 1'b0;
      rspDone <= 1'b0;
      rspErr  <= 1'b0;
    end else begin
      state   <= nextState;
      rspDone <= finish | abort;
      rspErr  <= abort;
      if (strb.load) opWrite <= reqWrite;
      if (nextState != state) pollCnt <= '0;
      else if (isWait)        pollCnt <= pollCnt + 1'b1;
    end
  end

  assign reqReady = (state == ST_IDLE);

  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= LAST_POLL);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> reqReady);
endmodule

// File: rtl/phy_cr_dp.sv
module phy_cr_dp
  import phy_cr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [STAT_W-1:0] statIn,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] addrReg, dataReg, effAddr;
  logic [CTRL_W-1:0] ctrlNext;

  assign effAddr = strb.load ? reqAddr : addrReg;

  always_comb begin
    ctrlNext = '0;
    case (strb.sel)
      SEL_ADDR:      ctrlNext[DATA_W-1:0] = effAddr;
      SEL_ADDR_CAPA: begin
        ctrlNext[DATA_W-1:0] = effAddr;
        ctrlNext[CAPA_BIT]   = 1'b1;
      end
      SEL_RD:        ctrlNext[RD_BIT] = 1'b1;
      SEL_DATA:      ctrlNext[DATA_W-1:0] = dataReg;
      SEL_DATA_CAPD: begin
        ctrlNext[DATA_W-1:0] = dataReg;
        ctrlNext[CAPD_BIT]   = 1'b1;
      end
      SEL_WR:        ctrlNext[WR_BIT] = 1'b1;
      default:       ctrlNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      ctrlOut <= '0;
      rdData  <= '0;
    end else begin
      ctrlOut <= ctrlNext;
      if (strb.load) begin
        addrReg <= reqAddr;
        dataReg <= reqWdata;
      end
      if (strb.latchRd) rdData <= statIn[DATA_W-1:0];
    end
  end

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlOut[RD_BIT:CAPA_BIT]));

  // R2
  capa_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOut[CAPA_BIT]) |->
      ($past(ctrlOut[DATA_W-1:0]) == ctrlOut[DATA_W-1:0]) &&
      ($past(ctrlOut[RD_BIT:CAPA_BIT]) == 4'b0000));

  // R4
  capd_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlOut[CAPD_BIT]) |->
      ($past(ctrlOut[DATA_W-1:0]) == ctrlOut[DATA_W-1:0]) &&
      ($past(ctrlOut[RD_BIT:CAPA_BIT]) == 4'b0000));
endmodule

// File: rtl/phyCrMaster.sv
module phyCrMaster
  import phy_cr_pkg::*;
#(
  parameter int MAX_POLLS = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [15:0] reqWdata,
  output logic        reqReady,
  output logic        rspDone,
  output logic        rspErr,
  output logic [15:0] rspRdata,
  output logic [19:0] crCtrl,
  input  logic [16:0] crStat
);
  dpStrobes_t strb;

  phy_cr_ctrl #(.MAX_POLLS(MAX_POLLS)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .ackIn(crStat[ACK_BIT]), .reqReady(reqReady), .rspDone(rspDone),
    .rspErr(rspErr), .strb(strb)
  );

  phy_cr_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .statIn(crStat), .ctrlOut(crCtrl), .rdData(rspRdata)
  );

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && rspErr) |-> (crCtrl == '0));

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (crCtrl == '0));
endmodule

// File: tb/test_phyCrMaster.sv
module test_phyCrMaster;
  localparam int CLK_PERIOD = 10;
  localparam int POLLS = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic reqReady, rspDone, rspErr;
  logic [15:0] rspRdata;
  logic [19:0] crCtrl;
  logic [16:0] crStat = '0;

  int checks = 0, fails = 0, cycles = 0;

  phyCrMaster i_phyCrMaster (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdata(rspRdata),
    .crCtrl(crCtrl), .crStat(crStat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY responder
  int respDelay = 0;
  int respMode = 0;   // 0 normal, 1 ack stuck low, 2 ack stuck high
  logic [127:0] hist = '0;
  logic [15:0] capAddr = '0, capData = '0, wrAddr = '0, wrData = '0;
  int wrCount = 0, multiStrobe = 0;

  // reference model state
  int mCtrl = 0, mDone = 0, mErr = 0, mReady = 1, mRd = 0;
  int mIdle = 1, mStep = 0, mPolls = 0, mN = 0;
  int sc[8], sw[8];

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mDone = 0; mErr = 0; mReady = 1; mRd = 0;
      mIdle = 1; mStep = 0; mPolls = 0;
    end else begin
      mDone = 0; mErr = 0;
      if (mIdle == 1) begin
        if (reqValid) begin
          if (reqWrite) begin
            sc[0] = reqAddr;              sw[0] = 0;
            sc[1] = reqAddr + (1 << 16);  sw[1] = 1;
            sc[2] = reqAddr;              sw[2] = 2;
            sc[3] = reqWdata;             sw[3] = 0;
            sc[4] = reqWdata + (1 << 17); sw[4] = 1;
            sc[5] = reqWdata;             sw[5] = 2;
            sc[6] = (1 << 18);            sw[6] = 1;
            sc[7] = reqWdata;             sw[7] = 2;
            mN = 8;
          end else begin
            sc[0] = reqAddr;              sw[0] = 0;
            sc[1] = reqAddr + (1 << 16);  sw[1] = 1;
            sc[2] = reqAddr;              sw[2] = 2;
            sc[3] = (1 << 19);            sw[3] = 3;
            sc[4] = 0;                    sw[4] = 2;
            mN = 5;
          end
          mIdle = 0; mStep = 0; mPolls = 0; mCtrl = sc[0];
        end else mCtrl = 0;
      end else begin
        automatic int adv = 0;
        automatic int abt = 0;
        automatic int want = (sw[mStep] == 2) ? 0 : 1;
        if (sw[mStep] == 0) adv = 1;
        else if (int'(crStat[16]) == want) begin
          adv = 1;
          if (sw[mStep] == 3) mRd = int'(crStat[15:0]);
        end else if (mPolls == POLLS - 1) abt = 1;
        else mPolls++;
        if (abt == 1) begin
          mIdle = 1; mCtrl = 0; mDone = 1; mErr = 1;
        end else if (adv == 1) begin
          mStep++; mPolls = 0;
          if (mStep == mN) begin
            mIdle = 1; mCtrl = 0; mDone = 1;
          end else mCtrl = sc[mStep];
        end
      end
      mReady = mIdle;
    end
  end

  // per-cycle compare, then responder update
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks++;
      if (int'(crCtrl) != mCtrl || int'(rspDone) != mDone || int'(rspErr) != mErr
          || int'(reqReady) != mReady) begin
        fails++;
        $display("FAIL R2/R8/R9 cycle %0d: ctrl=%h done=%b err=%b ready=%b expected ctrl=%h done=%0d err=%0d ready=%0d",
                 cycles, crCtrl, rspDone, rspErr, reqReady, mCtrl, mDone, mErr, mReady);
      end
      if (rspDone && !rspErr) begin
        checks++;
        if (int'(rspRdata) != mRd) begin
          fails++;
          $display("FAIL R3 rdata=%h expected %h", rspRdata, mRd);
        end
      end
    end
    if ($countones(crCtrl[19:16]) > 1) multiStrobe++;
    if (crCtrl[16]) capAddr = crCtrl[15:0];
    if (crCtrl[17]) capData = crCtrl[15:0];
    if (crCtrl[18] && !hist[0]) begin wrAddr = capAddr; wrData = capData; wrCount++; end
    hist = {hist[126:0], |crCtrl[19:16]};
    crStat[15:0] = capAddr ^ 16'hA5C3;
    crStat[16] = (respMode == 1) ? 1'b0 : (respMode == 2) ? 1'b1 : hist[respDelay];
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one transfer; holdBusy keeps reqValid high with altered inputs while busy
  task automatic doOp(input bit wr, input logic [15:0] a, input logic [15:0] d,
                      input bit holdBusy, output bit gotErr, output logic [15:0] gotRd,
                      output logic [19:0] ctrlAtDone);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    if (holdBusy) begin reqAddr = 16'hDEAD; reqWdata = 16'hDEAD; reqWrite = 1'b1; end
    else reqValid = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (rspDone) break;
      @(negedge clk);
    end
    reqValid = 1'b0;
    gotErr = rspErr; gotRd = rspRdata; ctrlAtDone = crCtrl;
    check("R9 done seen", int'(rspDone), 1);
    @(negedge clk);
    check("R9 done single cycle", int'(rspDone), 0);
    repeat (respDelay + 4) @(negedge clk);
  endtask

  initial begin
    bit e; logic [15:0] rd; logic [19:0] cd;
    repeat (3) @(negedge clk);
    check("R10 ctrl reset", int'(crCtrl), 0);
    check("R10 ready reset", int'(reqReady), 1);
    check("R10 done reset", int'(rspDone), 0);
    rstN = 1'b1;
    @(negedge clk);

    respDelay = 0;
    doOp(1'b0, 16'h1234, 16'h0, 1'b0, e, rd, cd);
    check("R3 read err", int'(e), 0);
    check("R3 read data", int'(rd), int'(16'h1234 ^ 16'hA5C3));

    respDelay = 3;
    doOp(1'b1, 16'h0011, 16'hBEEF, 1'b0, e, rd, cd);
    check("R4 write err", int'(e), 0);
    check("R1 write addr field", int'(wrAddr), 16'h0011);
    check("R4 write data", int'(wrData), 16'hBEEF);
    check("R4 final clear", int'(cd), 0);

    respDelay = 5;
    doOp(1'b0, 16'h100D, 16'h0, 1'b1, e, rd, cd);
    check("R8 busy request ignored", int'(capAddr), 16'h100D);
    check("R8 read data busy", int'(rd), int'(16'h100D ^ 16'hA5C3));
    check("R8 no write done", wrCount, 1);

    respDelay = POLLS - 1;
    doOp(1'b0, 16'h0042, 16'h0, 1'b0, e, rd, cd);
    check("R6 ack on last poll passes", int'(e), 0);

    respDelay = POLLS;
    doOp(1'b1, 16'h0043, 16'h5555, 1'b0, e, rd, cd);
    check("R6 ack one poll late aborts", int'(e), 1);
    check("R7 ctrl cleared at abort", int'(cd), 0);

    respDelay = 0; respMode = 1;
    doOp(1'b0, 16'h0077, 16'h0, 1'b0, e, rd, cd);
    check("R6 ack stuck low aborts", int'(e), 1);
    check("R7 ctrl cleared stuck low", int'(cd), 0);

    respMode = 2;
    doOp(1'b1, 16'h0078, 16'h1111, 1'b0, e, rd, cd);
    check("R6 ack stuck high aborts", int'(e), 1);
    check("R7 ctrl cleared stuck high", int'(cd), 0);
    respMode = 0;
    repeat (4) @(negedge clk);

    doOp(1'b1, 16'h2000, 16'hA5A5, 1'b0, e, rd, cd);
    check("R4 write after abort", int'(e), 0);
    check("R4 write data after abort", int'(wrData), 16'hA5A5);
    check("R5 single strobe", multiStrobe, 0);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule